// File: doc/BRIEF.md
# Per-CPU Doorbell and MSI Trigger Unit

This block raises software-generated interrupts for a small cluster of processors. Any bus master can post a single trigger word to a global register. The word names one doorbell number and a bitmap of the CPUs that should receive it. Each CPU owns a pending register and an enable register. The low doorbells (0 to 7) carry inter-processor signals. The high doorbells (16 to 31) carry message-signalled interrupts posted by devices. A device posts one by writing a fixed data pattern to the same trigger address.

For every CPU the unit drives two level outputs. One summarises the enabled, pending inter-processor doorbells. The other summarises the enabled, pending message doorbells. Downstream these feed sources 0 and 1 of an interrupt distributor.

Software acknowledges doorbells through the CPU's own pending register. A bit written 0 is cleared and a bit written 1 is left alone, so a handler can clear exactly the bits it has just serviced. The global trigger path and the per-CPU register path are separate write ports, so a trigger and an acknowledge can arrive in the same cycle. A combinational read port exposes any CPU's registers.

Top module: `doorbell_hub`

## Requirements
- R1: After a synchronous reset, every pending and enable register of every CPU reads zero, and all `ipi_irq` and `msi_irq` outputs are low.
- R2: A trigger-port write to address 0x4 sets pending bit `num` in each CPU k whose map bit is set, and leaves all other CPUs unchanged. The map bit for CPU k is data bit 8+k, and `num` is data[4:0].
- R3: A trigger write with data 0xF00 | (n+16), for n from 0 to 15, sets pending bit n+16 in all four CPUs.
- R4: A trigger write whose number lies in 8..15 changes no register. A trigger-port write to any address other than 0x4 also changes no register.
- R5: A CPU-port write to address 0x8 clears each pending bit of the selected CPU where the data bit is 0, and keeps each bit where the data bit is 1. A write of 0 clears every pending doorbell of that CPU.
- R6: A CPU-port write to address 0xC stores data bits [7:0] and [31:16] as that CPU's enable bits. Bits [15:8] of the enable and pending registers always read 0.
- R7: `ipi_irq[k]` is high exactly when some bit in [7:0] is both pending and enabled for CPU k. It follows a register update on the next cycle.
- R8: `msi_irq[k]` is high exactly when some bit in [31:16] is both pending and enabled for CPU k. It follows a register update on the next cycle.
- R9: When a trigger sets a bit and an acknowledge write clears the same bit of the same CPU in the same cycle, the bit ends up set.
- R10: `rd_data` returns the pending register of CPU `rd_sel` at address 0x8, its enable register at 0xC, and 0 at any other address, with no clock delay.
- R11: A CPU-port write to one CPU's pending register leaves the pending registers of all other CPUs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_we | input | 1 | Global trigger-port write strobe |
| trig_addr | input | 4 | Global trigger-port address (0x4 is the trigger) |
| trig_wdata | input | 32 | Trigger word: [11:8] CPU map, [4:0] doorbell number |
| cpu_we | input | 1 | Per-CPU register write strobe |
| cpu_sel | input | 2 | CPU whose registers the write targets |
| cpu_addr | input | 4 | 0x8 pending register, 0xC enable register |
| cpu_wdata | input | 32 | Per-CPU write data |
| rd_sel | input | 2 | CPU whose registers are read |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Read data |
| ipi_irq | output | 4 | Per-CPU inter-processor doorbell summary |
| msi_irq | output | 4 | Per-CPU message doorbell summary |

## Verification
The assertions assume that `cpu_sel` never names a CPU beyond the configured count. They also assume that each write port carries at most one write per cycle, which holds by the port structure. The stimulus only ever selects CPUs 0 to 3. It drives the two write ports independently, so same-cycle trigger-and-acknowledge collisions occur, both deliberately and in the randomised phase. Trigger numbers in that phase are drawn from the full 0..31 range, so the reserved numbers 8 to 15 are exercised alongside valid ones.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;

    localparam int DB_W      = 32;
    localparam int DB_AW     = 4;
    localparam int DB_NUM_W  = 5;
    localparam int DB_MAX_CPU = 4;
    localparam int DB_MAP_LSB = 8;
    localparam int DB_IPI_LO = 0;
    localparam int DB_IPI_N  = 8;
    localparam int DB_MSI_LO = 16;
    localparam int DB_MSI_N  = 16;

    localparam logic [DB_AW-1:0] DB_A_TRIG  = 4'h4;
    localparam logic [DB_AW-1:0] DB_A_CAUSE = 4'h8;
    localparam logic [DB_AW-1:0] DB_A_MASK  = 4'hC;

    typedef struct packed {
        logic [DB_MAX_CPU-1:0] map;
        logic [DB_NUM_W-1:0]   num;
    } trig_word_t;

    function automatic trig_word_t db_unpack(input logic [DB_W-1:0] d);
        trig_word_t t;
        t.map = d[DB_MAP_LSB +: DB_MAX_CPU];
        t.num = d[DB_NUM_W-1:0];
        return t;
    endfunction

    function automatic logic db_num_ok(input logic [DB_NUM_W-1:0] n);
        int v;
        v = int'(n);
        return ((v >= DB_IPI_LO) && (v < DB_IPI_LO + DB_IPI_N)) ||
               ((v >= DB_MSI_LO) && (v < DB_MSI_LO + DB_MSI_N));
    endfunction

    function automatic logic [DB_W-1:0] db_field(input int lo, input int n);
        logic [DB_W-1:0] m;
        m = '0;
        for (int i = 0; i < DB_W; i++)
            if (i >= lo && i < lo + n) m[i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/db_trig_decode.sv
module db_trig_decode
    import doorbell_pkg::*;
#(
    parameter int NCPU  = DB_MAX_CPU,
    parameter int DW    = DB_W,
    parameter int AW    = DB_AW
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     trig_we,
    input  logic [AW-1:0]            trig_addr,
    input  logic [DW-1:0]            trig_wdata,
    output logic [NCPU-1:0][DW-1:0]  set_vec
);

    trig_word_t word;
    logic       fire;
    logic [DW-1:0] one_hot;

    always_comb begin
        word    = db_unpack(trig_wdata);
        fire    = trig_we && (trig_addr == DB_A_TRIG) && db_num_ok(word.num);
        one_hot = DW'(1) << word.num;
    end

    for (genvar k = 0; k < NCPU; k++) begin : g_cpu
        always_comb set_vec[k] = (fire && word.map[k]) ? one_hot : '0;
    end

    // R4: reserved numbers and foreign addresses produce no set request
    assert_reserved_num_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (trig_we && (trig_wdata[DB_NUM_W-1:0] >= 5'd8) && (trig_wdata[DB_NUM_W-1:0] <= 5'd15))
        |-> (set_vec == '0));
    assert_foreign_addr_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (trig_addr != DB_A_TRIG) |-> (set_vec == '0));

endmodule

// File: rtl/db_cpu_bank.sv
module db_cpu_bank
    import doorbell_pkg::*;
#(
    parameter int DW     = DB_W,
    parameter int AW     = DB_AW,
    parameter int IPI_LO = DB_IPI_LO,
    parameter int IPI_N  = DB_IPI_N,
    parameter int MSI_LO = DB_MSI_LO,
    parameter int MSI_N  = DB_MSI_N
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [DW-1:0]  set_vec,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [DW-1:0]  wr_data,
    output logic [DW-1:0]  cause_q,
    output logic [DW-1:0]  mask_q,
    output logic           ipi_irq,
    output logic           msi_irq
);

    localparam logic [DW-1:0] IPI_F = DW'(db_field(IPI_LO, IPI_N));
    localparam logic [DW-1:0] MSI_F = DW'(db_field(MSI_LO, MSI_N));
    localparam logic [DW-1:0] VALID = IPI_F | MSI_F;

    logic          cause_wr;
    logic          mask_wr;
    logic [DW-1:0] keep;
    logic [DW-1:0] cause_d;
    logic [DW-1:0] mask_d;
    logic [DW-1:0] pending;

    always_comb begin
        cause_wr = wr_en && (wr_addr == DB_A_CAUSE);
        mask_wr  = wr_en && (wr_addr == DB_A_MASK);
        keep     = cause_wr ? wr_data : '1;
        // set is merged after the clear, so a same-cycle set survives
        cause_d  = ((cause_q & keep) | set_vec) & VALID;
        mask_d   = mask_wr ? (wr_data & VALID) : mask_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
            mask_q  <= '0;
        end else begin
            cause_q <= cause_d;
            mask_q  <= mask_d;
        end
    end

    always_comb begin
        pending = cause_q & mask_q;
        ipi_irq = |pending[IPI_LO +: IPI_N];
        msi_irq = |pending[MSI_LO +: MSI_N];
    end

    // R9: a requested set is visible on the next cycle, whatever the clear did
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((cause_q & $past(set_vec)) == $past(set_vec)));
    // R5: an acknowledge with no competing set leaves exactly the kept bits
    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == DB_A_CAUSE) && (set_vec == '0))
        |=> (cause_q == ($past(cause_q) & $past(wr_data))));
    // R11: without an acknowledge to this CPU no pending bit is lost
    assert_no_foreign_clear_R11: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (wr_addr == DB_A_CAUSE))
        |=> ((cause_q & $past(cause_q)) == $past(cause_q)));
    // R6: enable write stores only the implemented fields
    assert_mask_store_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == DB_A_MASK)) |=> (mask_q == ($past(wr_data) & VALID)));
    // R7 / R8: a summary can only be high when its enable field is non-zero
    assert_ipi_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
        ipi_irq |-> ((mask_q & IPI_F) != '0));
    assert_msi_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
        msi_irq |-> ((mask_q & MSI_F) != '0));

endmodule

// File: rtl/doorbell_hub.sv
module doorbell_hub
    import doorbell_pkg::*;
#(
    parameter int NCPU = DB_MAX_CPU,
    parameter int DW   = DB_W,
    parameter int AW   = DB_AW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 trig_we,
    input  logic [AW-1:0]        trig_addr,
    input  logic [DW-1:0]        trig_wdata,
    input  logic                 cpu_we,
    input  logic [((NCPU > 1) ? $clog2(NCPU) : 1)-1:0] cpu_sel,
    input  logic [AW-1:0]        cpu_addr,
    input  logic [DW-1:0]        cpu_wdata,
    input  logic [((NCPU > 1) ? $clog2(NCPU) : 1)-1:0] rd_sel,
    input  logic [AW-1:0]        rd_addr,
    output logic [DW-1:0]        rd_data,
    output logic [NCPU-1:0]      ipi_irq,
    output logic [NCPU-1:0]      msi_irq
);

    localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1;

    logic [NCPU-1:0][DW-1:0] set_vec;
    logic [NCPU-1:0][DW-1:0] cause_q;
    logic [NCPU-1:0][DW-1:0] mask_q;

    db_trig_decode #(.NCPU(NCPU), .DW(DW), .AW(AW)) u_decode (
        .clk        (clk),
        .rst        (rst),
        .trig_we    (trig_we),
        .trig_addr  (trig_addr),
        .trig_wdata (trig_wdata),
        .set_vec    (set_vec)
    );

    for (genvar k = 0; k < NCPU; k++) begin : g_bank
        logic sel_me;
        always_comb sel_me = cpu_we && (cpu_sel == CPU_W'(k));

        db_cpu_bank #(.DW(DW), .AW(AW)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .set_vec (set_vec[k]),
            .wr_en   (sel_me),
            .wr_addr (cpu_addr),
            .wr_data (cpu_wdata),
            .cause_q (cause_q[k]),
            .mask_q  (mask_q[k]),
            .ipi_irq (ipi_irq[k]),
            .msi_irq (msi_irq[k])
        );
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_sel) < NCPU) begin
            if (rd_addr == DB_A_CAUSE)     rd_data = cause_q[rd_sel];
            else if (rd_addr == DB_A_MASK) rd_data = mask_q[rd_sel];
        end
    end

    // R1: the cycle after reset releases, every summary output is low
    assert_clean_after_reset_R1: assert property (@(posedge clk)
        $fell(rst) |-> ((ipi_irq == '0) && (msi_irq == '0)));
    // R10: unmapped read addresses return zero
    assert_unmapped_read_R10: assert property (@(posedge clk) disable iff (rst)
        ((rd_addr != DB_A_CAUSE) && (rd_addr != DB_A_MASK)) |-> (rd_data == '0));

endmodule

// File: tb/doorbell_hub_tb.sv
module doorbell_hub_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig_we = 1'b0;
    logic [3:0]  trig_addr = '0;
    logic [31:0] trig_wdata = '0;
    logic        cpu_we = 1'b0;
    logic [1:0]  cpu_sel = '0;
    logic [3:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [1:0]  rd_sel = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [3:0]  ipi_irq;
    logic [3:0]  msi_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    bit [31:0] m_cause [4];
    bit [31:0] m_mask  [4];

    always #5 clk = ~clk;

    doorbell_hub u_dut (
        .clk(clk), .rst(rst),
        .trig_we(trig_we), .trig_addr(trig_addr), .trig_wdata(trig_wdata),
        .cpu_we(cpu_we), .cpu_sel(cpu_sel), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data),
        .ipi_irq(ipi_irq), .msi_irq(msi_irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic bit [31:0] m_read(input int c, input logic [3:0] a);
        if (a == 4'h8) return m_cause[c];
        if (a == 4'hC) return m_mask[c];
        return 32'h0;
    endfunction

    task automatic model_step();
        if (rst) begin
            for (int k = 0; k < 4; k++) begin m_cause[k] = '0; m_mask[k] = '0; end
        end else begin
            if (cpu_we && cpu_addr == 4'h8) m_cause[cpu_sel] = m_cause[cpu_sel] & cpu_wdata;
            if (cpu_we && cpu_addr == 4'hC) m_mask[cpu_sel] = cpu_wdata & 32'hFFFF00FF;
            if (trig_we && trig_addr == 4'h4) begin
                int num;
                num = int'(trig_wdata[4:0]);
                if (num < 8 || num >= 16)
                    for (int k = 0; k < 4; k++)
                        if (trig_wdata[8+k]) m_cause[k] = m_cause[k] | (32'h1 << num);
            end
        end
    endtask

    task automatic compare_all();
        for (int k = 0; k < 4; k++) begin
            bit ei, em;
            ei = |(m_cause[k] & m_mask[k] & 32'h0000_00FF);
            em = |(m_cause[k] & m_mask[k] & 32'hFFFF_0000);
            chk(ipi_irq[k] == ei, "R7 ipi summary", 32'(ipi_irq[k]), 32'(ei));
            chk(msi_irq[k] == em, "R8 msi summary", 32'(msi_irq[k]), 32'(em));
        end
        chk(rd_data == m_read(int'(rd_sel), rd_addr), "R10 read port", rd_data, m_read(int'(rd_sel), rd_addr));
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        trig_we = 1'b0;
        cpu_we  = 1'b0;
    endtask

    task automatic trig(input logic [31:0] d);
        trig_we = 1'b1; trig_addr = 4'h4; trig_wdata = d;
        tick(); idle();
    endtask

    task automatic cpu_wr(input int c, input logic [3:0] a, input logic [31:0] d);
        cpu_we = 1'b1; cpu_sel = 2'(c); cpu_addr = a; cpu_wdata = d;
        tick(); idle();
    endtask

    task automatic rd_chk(input int c, input logic [3:0] a, input logic [31:0] exp, input string req);
        rd_sel = 2'(c); rd_addr = a;
        #1;
        chk(rd_data == exp, req, rd_data, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        rst = 1'b0;
        tick();

        // R1: reset state
        for (int k = 0; k < 4; k++) begin
            rd_chk(k, 4'h8, 32'h0, "R1 pending after reset");
            rd_chk(k, 4'hC, 32'h0, "R1 enable after reset");
        end
        chk(ipi_irq == 4'h0 && msi_irq == 4'h0, "R1 summaries low", {ipi_irq, msi_irq}, 32'h0);

        // R6: enable register keeps only implemented fields
        for (int k = 0; k < 4; k++) cpu_wr(k, 4'hC, 32'hFFFF_FFFF);
        rd_chk(2, 4'hC, 32'hFFFF_00FF, "R6 enable field layout");

        // R2: IPI 3 to CPUs 0 and 2
        trig(32'h0000_0503);
        rd_chk(0, 4'h8, 32'h0000_0008, "R2 cpu0 set");
        rd_chk(1, 4'h8, 32'h0000_0000, "R2 cpu1 untouched");
        rd_chk(2, 4'h8, 32'h0000_0008, "R2 cpu2 set");
        chk(ipi_irq == 4'b0101, "R7 ipi after trigger", 32'(ipi_irq), 32'h5);

        // R3: message vector n=5 reaches all CPUs
        trig(32'h0000_0F15);
        rd_chk(3, 4'h8, 32'h0020_0000, "R3 msi all cpus");
        chk(msi_irq == 4'b1111, "R8 msi after trigger", 32'(msi_irq), 32'hF);

        // R4: reserved number and foreign address
        trig(32'h0000_0F0A);
        rd_chk(1, 4'h8, 32'h0020_0000, "R4 reserved number ignored");
        trig_we = 1'b1; trig_addr = 4'h8; trig_wdata = 32'h0000_0F01;
        tick(); idle();
        rd_chk(1, 4'h8, 32'h0020_0000, "R4 foreign address ignored");

        // R5 / R11: acknowledge
        cpu_wr(0, 4'h8, 32'hFFFF_FFF7);
        rd_chk(0, 4'h8, 32'h0020_0000, "R5 clear by zero keeps ones");
        cpu_wr(2, 4'h8, 32'h0);
        rd_chk(2, 4'h8, 32'h0, "R5 write zero clears all");
        rd_chk(1, 4'h8, 32'h0020_0000, "R11 other cpu unchanged");

        // R9: same-cycle set and clear on cpu1 bit 1
        trig_we = 1'b1; trig_addr = 4'h4; trig_wdata = 32'h0000_0201;
        cpu_we = 1'b1; cpu_sel = 2'd1; cpu_addr = 4'h8; cpu_wdata = 32'h0;
        tick(); idle();
        rd_chk(1, 4'h8, 32'h0000_0002, "R9 set wins over clear");

        // R7 / R8: masking hides pending bits
        cpu_wr(3, 4'hC, 32'h0);
        chk(msi_irq[3] == 1'b0, "R8 masked msi low", 32'(msi_irq[3]), 32'h0);
        rd_chk(0, 4'h0, 32'h0, "R10 unmapped address");

        // randomised phase, model compared every clock
        for (int i = 0; i < 2000; i++) begin
            trig_we    = ($urandom_range(0, 2) == 0);
            trig_addr  = ($urandom_range(0, 7) == 0) ? 4'(4 * $urandom_range(0, 3)) : 4'h4;
            trig_wdata = {20'h0, 4'($urandom), 3'($urandom), 5'($urandom)};
            cpu_we     = ($urandom_range(0, 3) == 0);
            cpu_sel    = 2'($urandom);
            cpu_addr   = ($urandom_range(0, 1) == 0) ? 4'h8 : 4'hC;
            cpu_wdata  = $urandom;
            rd_sel     = 2'($urandom);
            rd_addr    = 4'(4 * $urandom_range(0, 3));
            tick();
        end
        idle();
        tick();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule